// File: doc/BRIEF.md
# Glitch-Free Output Clock Gate with Power-Down Sequencing

This block sits between a clock synthesizer's core and its two output pins. It takes a modulated main clock and an unmodulated reference clock, both free-running, and decides cycle by cycle whether each one reaches its pin. Three things can stop a clock. The first is an asynchronous active-low power-down pin. The second is a per-output enable bit from a control register. The third is a settle timer that keeps both outputs quiet after power-down is released, until the oscillator can be trusted. The timer's length is a terminal count in reference-clock cycles, and the pin may not stay stopped longer than 3.0 ms.

Each output has its own gate flop, which switches only on the falling edge of the clock it gates. A clock therefore stops after a complete high pulse and restarts with a complete high pulse. A stopped output is always driven low. A separate control bit chooses whether its output-enable also drops, so that a stopped pin floats instead of being held low. While power-down is held, the block also drives a power-down request to the PLL.

Top module: `clk_out_gate_ctrl`

## Requirements
- R1: `pd_n_i` is synchronized by two rising edges of `clk_ref_i`. When `pd_n_i` is sampled low at reference edge k, `pll_pd_o` is high after edge k+1. `pll_pd_o` is the inverse of the synchronized pin level.
- R2: While the synchronized power-down is asserted, both clock outputs stay low and `pll_pd_o` stays high. The reference gate is closed no later than SYNC_STAGES+2 reference rising edges after `pll_pd_o` rises.
- R3: A clock output only changes its running state while its source clock is low. Every high pulse on `clk_main_o` and `clk_ref_o` lasts a full source high phase.
- R4: Take E0 as the reference rising edge just before `pd_n_i` goes high, with the pin then staying high. The first rising edge on `clk_ref_o` is reference edge E0+`stable_tc_i`+6, given the reference enable has long been 1. If power-down is reasserted before the count completes, the count starts again from zero.
- R5: Each output has its own enable: `en_main_i` and `en_ref_i`. An enable is sampled by two rising edges of its own clock, and the gate follows at the next falling edge. A disabled output is driven low while the other one keeps running.
- R6: A clock that is enabled again, or released after power-down, starts with a full-width first high pulse and no glitch.
- R7: When `tri_en_i` is 1, the output-enable of a stopped output is 0. In every other case the output-enable is 1. The clock pin itself is low whenever its clock is stopped.
- R8: While `rst_n` is low, both clock outputs are low and `pll_pd_o` is 1. After reset the outputs stay stopped until the synchronizers and the settle timer let them run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Free-running modulated main clock |
| clk_ref_i | input | 1 | Free-running reference clock; clocks the settle timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down pin |
| en_main_i | input | 1 | Main output enable bit |
| en_ref_i | input | 1 | Reference output enable bit |
| tri_en_i | input | 1 | 1: a stopped output floats; 0: a stopped output is driven low |
| stable_tc_i | input | CNT_W | Settle timer terminal count, in reference cycles |
| clk_main_o | output | 1 | Gated main clock |
| clk_ref_o | output | 1 | Gated reference clock |
| oe_main_o | output | 1 | Output-enable for the main clock pin |
| oe_ref_o | output | 1 | Output-enable for the reference clock pin |
| pll_pd_o | output | 1 | Power-down request to the PLL and VCO |

## Verification
Four properties are checked on every clock:
- each gate flop agrees with its synchronized run and enable levels, so it can only have moved on a falling edge;
- a synchronized power-down clears the settle flag on the next edge;
- the settle flag never rises before the count has reached the terminal value;
- a sustained power-down request closes the reference gate within a bounded number of edges.

Some behaviours only the bench scenarios can show. These are the exact latency from pin release to the first reference pulse, the count starting again after a brief reassertion, full-width first pulses after re-enable, and the output-enable behaviour under the tri-state selection. The bench shows them against a behavioural model compared every half cycle.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/100ps
package clkgate_pkg;
    localparam int unsigned N_OUT   = 2;
    localparam int unsigned OUT_MAIN = 0;
    localparam int unsigned OUT_REF  = 1;
endpackage

// File: rtl/clkgate_settle_timer.sv
`timescale 1ns/100ps
module clkgate_settle_timer #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 20
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             pd_n_i,
    input  logic [CNT_W-1:0] tc_i,
    output logic             stable_o,
    output logic             pd_req_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] pd_sync;
        logic [CNT_W-1:0]       cnt;
        logic                   stable;
    } timer_t;

    timer_t st_d, st_q;
    logic   pd_up;

    assign pd_up = st_q.pd_sync[SYNC_STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.pd_sync = {st_q.pd_sync[SYNC_STAGES-2:0], pd_n_i};
        if (!pd_up) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < tc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.stable = pd_up && (st_q.cnt >= tc_i);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stable_o = st_q.stable;
    assign pd_req_o = ~pd_up;

    // R2: a synchronized power-down drops the settle flag on the next edge
    p_pd_clears_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
        !pd_up |=> !st_q.stable);

    // R4: the settle flag only rises once the count has reached the terminal value
    p_stable_after_count_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(st_q.stable) |-> $past(pd_up && (st_q.cnt >= tc_i)));
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/100ps
module clkgate_cell #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic run_i,
    input  logic en_i,
    input  logic tri_i,
    output logic clk_o,
    output logic oe_o,
    output logic gate_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] run;
        logic [SYNC_STAGES-1:0] en;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  run_s, en_s;
    logic  gate_d, gate_q;

    assign run_s = sync_q.run[SYNC_STAGES-1];
    assign en_s  = sync_q.en[SYNC_STAGES-1];

    always_comb begin
        sync_d     = sync_q;
        sync_d.run = {sync_q.run[SYNC_STAGES-2:0], run_i};
        sync_d.en  = {sync_q.en[SYNC_STAGES-2:0], en_i};
        gate_d     = run_s & en_s;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // gate only moves while the source clock is low
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign clk_o  = clk_i & gate_q;
    assign oe_o   = gate_q | ~tri_i;
    assign gate_o = gate_q;

    // R5: during each high phase the gate matches the synchronized request
    p_gate_follows_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
        gate_q == (run_s & en_s));
endmodule

// File: rtl/clk_out_gate_ctrl.sv
`timescale 1ns/100ps
module clk_out_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 20
) (
    input  logic             clk_main_i,
    input  logic             clk_ref_i,
    input  logic             rst_n,
    input  logic             pd_n_i,
    input  logic             en_main_i,
    input  logic             en_ref_i,
    input  logic             tri_en_i,
    input  logic [CNT_W-1:0] stable_tc_i,
    output logic             clk_main_o,
    output logic             clk_ref_o,
    output logic             oe_main_o,
    output logic             oe_ref_o,
    output logic             pll_pd_o
);
    localparam int unsigned HOLD   = SYNC_STAGES + 1;
    localparam int unsigned HOLD_W = $clog2(HOLD + 1);

    logic             stable_w;
    logic [N_OUT-1:0] clk_src, en_src, clk_gated, oe_w, gate_w;

    clkgate_settle_timer #(
        .SYNC_STAGES(SYNC_STAGES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk_i   (clk_ref_i),
        .rst_n   (rst_n),
        .pd_n_i  (pd_n_i),
        .tc_i    (stable_tc_i),
        .stable_o(stable_w),
        .pd_req_o(pll_pd_o)
    );

    assign clk_src[OUT_MAIN] = clk_main_i;
    assign clk_src[OUT_REF]  = clk_ref_i;
    assign en_src[OUT_MAIN]  = en_main_i;
    assign en_src[OUT_REF]   = en_ref_i;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk_i (clk_src[g]),
            .rst_n (rst_n),
            .run_i (stable_w),
            .en_i  (en_src[g]),
            .tri_i (tri_en_i),
            .clk_o (clk_gated[g]),
            .oe_o  (oe_w[g]),
            .gate_o(gate_w[g])
        );
    end

    assign clk_main_o = clk_gated[OUT_MAIN];
    assign clk_ref_o  = clk_gated[OUT_REF];
    assign oe_main_o  = oe_w[OUT_MAIN];
    assign oe_ref_o   = oe_w[OUT_REF];

    // run length of the power-down request, used to bound the stop latency
    logic [HOLD_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!pll_pd_o) begin
            hold_d = '0;
        end else if (hold_q != HOLD_W'(HOLD)) begin
            hold_d = hold_q + 1'b1;
        end
    end

    always_ff @(posedge clk_ref_i or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R2: a sustained power-down request has closed the reference gate
    p_pd_stops_ref_r2: assert property (@(posedge clk_ref_i) disable iff (!rst_n)
        (hold_q == HOLD_W'(HOLD)) |-> !gate_w[OUT_REF]);
endmodule

// File: tb/clk_out_gate_ctrl_tb.sv
`timescale 1ns/100ps
module clk_out_gate_ctrl_tb;
    localparam int CNT_W = 20;

    logic clk_main = 1'b0;
    logic clk_ref  = 1'b0;
    logic rst_n    = 1'b0;
    logic pd_n     = 1'b0;
    logic en_main  = 1'b1;
    logic en_ref   = 1'b1;
    logic tri_en   = 1'b0;
    logic [CNT_W-1:0] tc = 20'd5;
    logic clk_main_o, clk_ref_o, oe_main_o, oe_ref_o, pll_pd_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    clk_out_gate_ctrl #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_dut (
        .clk_main_i (clk_main),
        .clk_ref_i  (clk_ref),
        .rst_n      (rst_n),
        .pd_n_i     (pd_n),
        .en_main_i  (en_main),
        .en_ref_i   (en_ref),
        .tri_en_i   (tri_en),
        .stable_tc_i(tc),
        .clk_main_o (clk_main_o),
        .clk_ref_o  (clk_ref_o),
        .oe_main_o  (oe_main_o),
        .oe_ref_o   (oe_ref_o),
        .pll_pd_o   (pll_pd_o)
    );

    // reference at 250 MHz; main edges fall on half-ns points, never on a reference edge
    initial forever #2 clk_ref = ~clk_ref;
    initial begin
        #0.5;
        forever #3 clk_main = ~clk_main;
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_pd_a, m_pd_seen, m_stable;
    int m_age;
    bit r_run_a, r_run_b, r_en_a, r_en_b, g_ref;
    bit mn_run_a, mn_run_b, mn_en_a, mn_en_b, g_main;

    always @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            m_pd_a <= 0; m_pd_seen <= 0; m_stable <= 0; m_age <= 0;
            r_run_a <= 0; r_run_b <= 0; r_en_a <= 0; r_en_b <= 0;
        end else begin
            m_pd_a    <= pd_n;
            m_pd_seen <= m_pd_a;
            m_age     <= m_pd_seen ? ((m_age < int'(tc)) ? m_age + 1 : m_age) : 0;
            m_stable  <= m_pd_seen && (m_age >= int'(tc));
            r_run_a   <= m_stable;
            r_run_b   <= r_run_a;
            r_en_a    <= en_ref;
            r_en_b    <= r_en_a;
        end
    end
    always @(negedge clk_ref or negedge rst_n) g_ref <= rst_n ? (r_run_b & r_en_b) : 1'b0;

    always @(posedge clk_main or negedge rst_n) begin
        if (!rst_n) begin
            mn_run_a <= 0; mn_run_b <= 0; mn_en_a <= 0; mn_en_b <= 0;
        end else begin
            mn_run_a <= m_stable;
            mn_run_b <= mn_run_a;
            mn_en_a  <= en_main;
            mn_en_b  <= mn_en_a;
        end
    end
    always @(negedge clk_main or negedge rst_n) g_main <= rst_n ? (mn_run_b & mn_en_b) : 1'b0;

    // ---------------- per-half-cycle comparison ----------------
    always @(posedge clk_ref) begin
        #0.7;
        if (rst_n && !done) begin
            chk("R5", "clk_ref_o high phase", clk_ref_o, g_ref);
            chk("R7", "oe_ref_o", oe_ref_o, g_ref | ~tri_en);
            chk("R1", "pll_pd_o", pll_pd_o, ~m_pd_seen);
        end
    end
    always @(negedge clk_ref) begin
        #0.7;
        if (rst_n && !done) chk("R3", "clk_ref_o low phase", clk_ref_o, 1'b0);
    end
    always @(posedge clk_main) begin
        #1.2;
        if (rst_n && !done) begin
            chk("R5", "clk_main_o high phase", clk_main_o, g_main);
            chk("R7", "oe_main_o", oe_main_o, g_main | ~tri_en);
        end
    end
    always @(negedge clk_main) begin
        #1.2;
        if (rst_n && !done) chk("R3", "clk_main_o low phase", clk_main_o, 1'b0);
    end

    // pulse width: every high pulse is a full source high phase
    realtime t_ref_rise, t_main_rise;
    int ref_rises  = 0;
    int main_rises = 0;
    always @(posedge clk_ref_o) begin t_ref_rise = $realtime; ref_rises++; end
    always @(posedge clk_main_o) begin t_main_rise = $realtime; main_rises++; end
    always @(negedge clk_ref_o) if (rst_n && !done)
        chk("R3/R6", "clk_ref_o pulse is 2.0 ns", (($realtime - t_ref_rise) > 1.95) && (($realtime - t_ref_rise) < 2.05), 1'b1);
    always @(negedge clk_main_o) if (rst_n && !done)
        chk("R3/R6", "clk_main_o pulse is 3.0 ns", (($realtime - t_main_rise) > 2.95) && (($realtime - t_main_rise) < 3.05), 1'b1);

    task automatic wait_ref(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    // counts reference edges from the one before the last drive until clk_ref_o is high
    task automatic first_ref_rise(output int n);
        bit seen;
        n = 0;
        seen = 0;
        while (!seen && n < 200) begin
            @(posedge clk_ref);
            n++;
            #0.7;
            if (clk_ref_o === 1'b1) seen = 1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL WDOG timeout: actual running expected finished at %0t", $time);
        finish_run();
    end

    initial begin
        int n;
        int rises0, mrises0;
        // R8: reset state
        wait_ref(3);
        #1;
        chk("R8", "clk_ref_o in reset", clk_ref_o, 1'b0);
        chk("R8", "clk_main_o in reset", clk_main_o, 1'b0);
        chk("R8", "pll_pd_o in reset", pll_pd_o, 1'b1);
        chk("R8", "oe_ref_o in reset, drive-low mode", oe_ref_o, 1'b1);
        tri_en = 1'b1;
        #0.2;
        chk("R7", "oe_main_o stopped with tri-state selected", oe_main_o, 1'b0);
        chk("R7", "oe_ref_o stopped with tri-state selected", oe_ref_o, 1'b0);
        wait_ref(1);
        tri_en = 1'b0;
        rst_n  = 1'b1;

        // R2: power-down held: everything stays low
        wait_ref(12);
        chk_int("R2", "ref pulses while powered down", ref_rises, 0);
        chk_int("R2", "main pulses while powered down", main_rises, 0);
        chk("R2", "pll_pd_o while powered down", pll_pd_o, 1'b1);

        // R4: release, first reference pulse after tc+6 edges
        pd_n = 1'b1;
        first_ref_rise(n);
        chk_int("R4", "edges to first ref pulse, tc=5", n, 5 + 6);
        wait_ref(30);
        chk("R6", "main clock running after release", main_rises > 0, 1'b1);

        // R5: main disabled, reference keeps running
        en_main = 1'b0;
        wait_ref(6);
        mrises0 = main_rises;
        rises0  = ref_rises;
        wait_ref(20);
        chk_int("R5", "main pulses while disabled", main_rises - mrises0, 0);
        chk_int("R5", "ref pulses while main disabled", ref_rises - rises0, 20);
        // R6: clean restart (pulse widths checked continuously)
        en_main = 1'b1;
        wait_ref(12);
        chk("R6", "main pulses after re-enable", main_rises > mrises0, 1'b1);

        // R7: reference disabled with tri-state selected
        tri_en = 1'b1;
        en_ref = 1'b0;
        wait_ref(8);
        chk("R7", "oe_ref_o of disabled ref", oe_ref_o, 1'b0);
        chk("R7", "oe_main_o of running main", oe_main_o, 1'b1);
        en_ref = 1'b1;
        tri_en = 1'b0;
        wait_ref(8);

        // R1: synchronizer latency of the power-down pin
        pd_n = 1'b0;
        @(posedge clk_ref); #0.7;
        chk("R1", "pll_pd_o one edge after pin low", pll_pd_o, 1'b0);
        @(posedge clk_ref); #0.7;
        chk("R1", "pll_pd_o two edges after pin low", pll_pd_o, 1'b1);
        wait_ref(12);
        rises0  = ref_rises;
        mrises0 = main_rises;
        wait_ref(10);
        chk_int("R2", "ref pulses during power-down", ref_rises - rises0, 0);
        chk_int("R2", "main pulses during power-down", main_rises - mrises0, 0);

        // R4: brief release, reassert before the count completes, then release again
        tc = 20'd10;
        wait_ref(2);
        pd_n = 1'b1;
        wait_ref(4);
        pd_n = 1'b0;
        wait_ref(4);
        chk_int("R4", "ref pulses during aborted count", ref_rises - rises0, 0);
        pd_n = 1'b1;
        first_ref_rise(n);
        chk_int("R4", "edges to first ref pulse after restart, tc=10", n, 10 + 6);
        wait_ref(10);

        // R4: zero terminal count
        pd_n = 1'b0;
        wait_ref(12);
        tc = 20'd0;
        wait_ref(2);
        pd_n = 1'b1;
        first_ref_rise(n);
        chk_int("R4", "edges to first ref pulse, tc=0", n, 0 + 6);
        wait_ref(20);

        finish_run();
    end
endmodule